// File: doc/BRIEF.md
# Radix-Adjusted Subtract-With-Borrow Execution Slice

This block is a 4-bit execution slice of a small nibble-oriented processor. It decodes a 13-bit instruction word and runs two subtract-with-borrow operations. The first is a memory form: it reads a nibble through the X or Y pointer, subtracts a 4-bit immediate and the incoming carry, writes the difference back to the same address, and then steps the pointer by one. The second is a register form: it subtracts register A and the carry from register B and folds the result into a radix from 1 to 16 that the opcode selects.

The slice owns the A, B, X and Y registers. Neighbouring logic presets them through a load port while the slice is idle. It reaches data memory through a simple synchronous nibble port, where read data arrives one clock after the read request. A start strobe launches an instruction. The current flags come in at start, and the updated flags go out when the instruction retires. Every legal instruction takes exactly two cycles. An unknown opcode is reported and leaves all state as it was.

Top module: `rsub_unit`

## Requirements
- R1: After reset, A, B, X, Y and flags_out are zero, and done, illegal, mem_re and mem_we are low.
- R2: When start is sampled, insn[12:4] = 0x189 selects the memory form through X, 0x18B selects the memory form through Y, and 0x10C selects the register form. insn[3:0] is the immediate for the memory forms and the radix code for the register form.
- R3: The memory form writes (mem[ptr] − imm − C) mod 16 back to address ptr. The new C is 1 exactly when the unsigned difference is negative.
- R4: The memory form adds one to the selected 16-bit pointer, wrapping from 0xFFFF to 0x0000, and leaves the other pointer unchanged.
- R5: The register form computes raw = B − A − C. B becomes raw + n with C = 1 when raw is negative, and raw with C = 0 otherwise. A is unchanged. The result is defined for A and B below n.
- R6: A radix code of 0000 means radix 16. Any other code is the radix itself.
- R7: flags_in and flags_out are laid out as {E, I, C, Z} from bit 3 down to bit 0. When an instruction retires, E becomes 0, I takes the value flags_in had at start, and Z is 1 exactly when the 4-bit result is zero.
- R8: In the cycle after the start edge, mem_re is high with mem_addr = ptr. In the next cycle, mem_we is high with the same address and done is high. Results appear at the edge that closes the done cycle. The register form never touches memory.
- R9: A start with any other opcode raises illegal for exactly one cycle. It gives no done and no memory access, and changes no register or flag.
- R10: A start or a register load that arrives while an instruction is in flight is ignored.
- R11: While the slice is idle and start is low, ld_en writes ld_data into the register chosen by ld_sel (0 = A, 1 = B, 2 = X, 3 = Y). A and B take the low 4 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch the instruction on insn |
| insn | input | 13 | Instruction word |
| flags_in | input | 4 | Current flags {E,I,C,Z} |
| ld_en | input | 1 | Register preload strobe |
| ld_sel | input | 2 | Preload target: 0 A, 1 B, 2 X, 3 Y |
| ld_data | input | 16 | Preload value |
| mem_addr | output | 16 | Nibble memory address |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 4 | Memory write data |
| mem_rdata | input | 4 | Memory read data, valid one cycle after mem_re |
| done | output | 1 | High in the second cycle of a legal instruction |
| illegal | output | 1 | One-cycle pulse after an unknown opcode |
| flags_out | output | 4 | Updated flags {E,I,C,Z} |
| a_o | output | 4 | Register A |
| b_o | output | 4 | Register B |
| x_o | output | 16 | Pointer X |
| y_o | output | 16 | Pointer Y |

## Verification
The register form is tried with radixes 1, 3, 5, 7, 8, 10 and 16, using operand pairs that give a positive difference, an exactly zero difference and a negative difference, each with and without the incoming carry. This separates the fold-back by n from plain mod-16 wrap, and it separates Z from C. The memory form is run through both pointers, including a pointer at 0xFFFF and a result that wraps below zero, which shows the write address, the pointer step and the borrow apart. An unknown opcode, and a second start plus a preload arriving mid-instruction, show that nothing moves when it should not.

// File: rtl/rsub_pkg.sv
package rsub_pkg;
    localparam int NIB_W  = 4;
    localparam int PTR_W  = 16;
    localparam int INSN_W = 13;
    localparam int FLG_W  = 4;

    typedef enum logic [1:0] {OP_ILL, OP_MEMX, OP_MEMY, OP_REG} op_e;
    typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} st_e;

    typedef struct packed {
        st_e              st;
        op_e              op;
        logic [NIB_W-1:0] nib;
        logic             cin;
        logic             iin;
        logic [NIB_W-1:0] a;
        logic [NIB_W-1:0] b;
        logic [PTR_W-1:0] x;
        logic [PTR_W-1:0] y;
        logic [FLG_W-1:0] flags;
        logic             ill;
    } core_t;
endpackage

// File: rtl/rsub_decode.sv
module rsub_decode
    import rsub_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output op_e               op,
    output logic [NIB_W-1:0]  nib
);
    localparam int HI_W = INSN_W - NIB_W;

    always_comb begin
        nib = insn[NIB_W-1:0];
        unique case (insn[INSN_W-1:NIB_W])
            HI_W'(9'h189): op = OP_MEMX;
            HI_W'(9'h18B): op = OP_MEMY;
            HI_W'(9'h10C): op = OP_REG;
            default:       op = OP_ILL;
        endcase
    end
endmodule

// File: rtl/rsub_radix_sub.sv
module rsub_radix_sub #(
    parameter int W = 4
) (
    input  logic [W-1:0] minu,
    input  logic [W-1:0] subt,
    input  logic         cin,
    input  logic [W-1:0] code,
    output logic [W-1:0] res,
    output logic         borrow
);
    localparam int RW = W + 1;
    localparam logic [RW-1:0] FULL = RW'(1) << W;

    logic [RW-1:0] raw;
    logic [RW-1:0] radix;
    logic [RW-1:0] folded;

    always_comb begin
        raw    = {1'b0, minu} - {1'b0, subt} - RW'(cin);
        radix  = (code == '0) ? FULL : {1'b0, code};
        folded = raw + radix;
        borrow = raw[W];
        res    = borrow ? folded[W-1:0] : raw[W-1:0];
    end

    // R5
    always_comb begin
        if ({1'b0, minu} < radix && {1'b0, subt} < radix)
            range_chk: assert ({1'b0, res} < radix);
    end
endmodule

// File: rtl/rsub_unit.sv
module rsub_unit
    import rsub_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [12:0]       insn,
    input  logic [3:0]        flags_in,
    input  logic              ld_en,
    input  logic [1:0]        ld_sel,
    input  logic [15:0]       ld_data,
    output logic [15:0]       mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [3:0]        mem_wdata,
    input  logic [3:0]        mem_rdata,
    output logic              done,
    output logic              illegal,
    output logic [3:0]        flags_out,
    output logic [3:0]        a_o,
    output logic [3:0]        b_o,
    output logic [15:0]       x_o,
    output logic [15:0]       y_o
);
    localparam int F_E = 3;
    localparam int F_I = 2;
    localparam int F_C = 1;

    core_t q, d;

    op_e              dec_op;
    logic [NIB_W-1:0] dec_nib;
    logic [NIB_W-1:0] alu_m, alu_s, alu_code, alu_res;
    logic             alu_bor;

    rsub_decode u_dec (
        .insn (insn),
        .op   (dec_op),
        .nib  (dec_nib)
    );

    // register form uses the opcode radix, memory form is plain binary
    always_comb begin
        if (q.op == OP_REG) begin
            alu_m    = q.b;
            alu_s    = q.a;
            alu_code = q.nib;
        end else begin
            alu_m    = mem_rdata;
            alu_s    = q.nib;
            alu_code = '0;
        end
    end

    rsub_radix_sub #(.W(NIB_W)) u_sub (
        .minu   (alu_m),
        .subt   (alu_s),
        .cin    (q.cin),
        .code   (alu_code),
        .res    (alu_res),
        .borrow (alu_bor)
    );

    always_comb begin
        d     = q;
        d.ill = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    if (dec_op == OP_ILL) begin
                        d.ill = 1'b1;
                    end else begin
                        d.st  = ST_RD;
                        d.op  = dec_op;
                        d.nib = dec_nib;
                        d.cin = flags_in[F_C];
                        d.iin = flags_in[F_I];
                    end
                end else if (ld_en) begin
                    unique case (ld_sel)
                        2'd0: d.a = ld_data[NIB_W-1:0];
                        2'd1: d.b = ld_data[NIB_W-1:0];
                        2'd2: d.x = ld_data;
                        default: d.y = ld_data;
                    endcase
                end
            end
            ST_RD: d.st = ST_WR;
            default: begin
                d.st = ST_IDLE;
                if (q.op == OP_REG)       d.b = alu_res;
                else if (q.op == OP_MEMX) d.x = q.x + 1'b1;
                else                      d.y = q.y + 1'b1;
                d.flags = {1'b0, q.iin, alu_bor, (alu_res == '0)};
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
            q.op <= OP_ILL;
        end else begin
            q <= d;
        end
    end

    assign mem_addr  = (q.op == OP_MEMY) ? q.y : q.x;
    assign mem_re    = (q.st == ST_RD) && (q.op != OP_REG);
    assign mem_we    = (q.st == ST_WR) && (q.op != OP_REG);
    assign mem_wdata = alu_res;
    assign done      = (q.st == ST_WR);
    assign illegal   = q.ill;
    assign flags_out = q.flags;
    assign a_o       = q.a;
    assign b_o       = q.b;
    assign x_o       = q.x;
    assign y_o       = q.y;

    // R8
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($past(mem_re) && mem_addr == $past(mem_addr)));

    // R8
    rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_re, mem_we, illegal}));

    // R4
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && q.op == OP_MEMX) |=> (x_o == PTR_W'($past(x_o) + 1'b1) && $stable(y_o)));

    // R7
    flag_e_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!flags_out[F_E] && flags_out[F_I] == $past(q.iin)));

    // R9
    ill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!done && !mem_re && $stable(a_o) && $stable(b_o)
                     && $stable(x_o) && $stable(y_o) && $stable(flags_out)));
endmodule

// File: tb/rsub_unit_tb_top.sv
module rsub_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [12:0] insn = '0;
    logic [3:0]  flags_in = '0;
    logic        ld_en = 1'b0;
    logic [1:0]  ld_sel = '0;
    logic [15:0] ld_data = '0;
    logic [15:0] mem_addr;
    logic        mem_re, mem_we, done, illegal;
    logic [3:0]  mem_wdata, flags_out, a_o, b_o;
    logic [3:0]  mem_rdata = '0;
    logic [15:0] x_o, y_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    rsub_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .insn(insn), .flags_in(flags_in),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .done(done), .illegal(illegal), .flags_out(flags_out),
        .a_o(a_o), .b_o(b_o), .x_o(x_o), .y_o(y_o)
    );

    // nibble memory model, 16 words indexed by the low address bits
    logic [3:0] mem [16];
    logic       pre_en = 1'b0;
    logic [3:0] pre_addr = '0;
    logic [3:0] pre_val = '0;
    always @(posedge clk) begin
        if (pre_en) mem[pre_addr] <= pre_val;
        else if (mem_we) mem[mem_addr[3:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[3:0]];
    end

    // {B, A, C, radix code, expected B, expected C}
    localparam logic [23:0] VEC [10] = '{
        24'h530A20, 24'h350A81, 24'h001A91, 24'h770800, 24'h2510C1,
        24'h001101, 24'h120321, 24'hF010E0, 24'h441541, 24'h611740
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic load(input logic [1:0] sel, input logic [15:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = sel; ld_data = v;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic preload(input logic [3:0] addr, input logic [3:0] v);
        @(negedge clk);
        pre_en = 1'b1; pre_addr = addr; pre_val = v;
        @(negedge clk);
        pre_en = 1'b0;
    endtask

    logic        s_re, s_we, s_done;
    logic [15:0] s_raddr, s_waddr;
    logic [3:0]  s_wdata;

    task automatic run(input logic [12:0] op, input logic [3:0] fl);
        @(negedge clk);
        start = 1'b1; insn = op; flags_in = fl;
        @(negedge clk);
        start = 1'b0;
        s_re = mem_re; s_raddr = mem_addr;
        @(negedge clk);
        s_we = mem_we; s_waddr = mem_addr; s_wdata = mem_wdata; s_done = done;
        @(negedge clk);
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 regs", {a_o, b_o, x_o, y_o}, '0);
        chk("R1 flags", {28'd0, flags_out}, 0);
        chk("R1 strobes", {done, illegal, mem_re, mem_we}, 0);

        // R5 R6 R7 register form table
        for (int i = 0; i < 10; i++) begin
            logic iv;
            logic [3:0] vb, va, vc, vn, eb, ec;
            {vb, va, vc, vn, eb, ec} = VEC[i];
            iv = i[0];
            load(2'd0, {12'd0, va});
            load(2'd1, {12'd0, vb});
            run({9'h10C, vn}, {1'b1, iv, vc[0], 1'b1});
            chk("R5 result", b_o, eb);
            chk("R5 A kept", a_o, va);
            chk("R7 flags", flags_out, {1'b0, iv, ec[0], (eb == 4'd0)});
            chk("R8 done reg form", {s_done, s_re, s_we}, 3'b100);
        end

        // R3 R4 R8 memory form through X, no borrow
        load(2'd2, 16'h0003);
        load(2'd3, 16'h1234);
        preload(4'd3, 4'd9);
        run(13'h1894, 4'b1010);
        chk("R8 read addr", {s_re, s_raddr}, {1'b1, 16'h0003});
        chk("R8 write", {s_we, s_done, s_waddr, s_wdata}, {2'b11, 16'h0003, 4'd4});
        chk("R4 X step", x_o, 16'h0004);
        chk("R4 Y kept", y_o, 16'h1234);
        chk("R7 mem flags", flags_out, 4'b0000);
        chk("R3 stored", mem[3], 4'd4);

        // R3 R4 memory form through Y, borrow and pointer wrap
        load(2'd3, 16'hFFFF);
        preload(4'd15, 4'd2);
        run(13'h18B5, 4'b0100);
        chk("R8 Y read addr", s_raddr, 16'hFFFF);
        chk("R3 borrow data", s_wdata, 4'hD);
        chk("R4 Y wrap", y_o, 16'h0000);
        chk("R4 X kept", x_o, 16'h0004);
        chk("R7 borrow flags", flags_out, 4'b0110);

        // R3 R7 zero result
        preload(4'd4, 4'd5);
        run(13'h1895, 4'b1000);
        chk("R3 zero data", s_wdata, 4'd0);
        chk("R7 Z set", flags_out, 4'b0001);
        chk("R4 X again", x_o, 16'h0005);

        // R9 illegal opcode
        @(negedge clk);
        start = 1'b1; insn = 13'h1880; flags_in = 4'b1111;
        @(negedge clk);
        start = 1'b0;
        chk("R9 illegal pulse", {illegal, done, mem_re}, 3'b100);
        @(negedge clk);
        chk("R9 pulse ends", {illegal, done, mem_re, mem_we}, 4'b0000);
        chk("R9 state kept", {b_o, x_o, y_o, flags_out}, {eb_last(), 16'h0005, 16'h0000, 4'b0001});

        // R10 start and load ignored while busy
        load(2'd0, 16'd1);
        load(2'd1, 16'd5);
        @(negedge clk);
        start = 1'b1; insn = 13'h10CA; flags_in = 4'b0000;
        @(negedge clk);
        insn = 13'h10C0; flags_in = 4'b0010;
        ld_en = 1'b1; ld_sel = 2'd0; ld_data = 16'd7;
        @(negedge clk);
        start = 1'b0; ld_en = 1'b0;
        chk("R10 done once", done, 1'b1);
        @(negedge clk);
        chk("R10 result", {a_o, b_o}, {4'd1, 4'd4});
        @(negedge clk);
        chk("R10 no second run", {done, b_o}, {1'b0, 4'd4});

        // R11 preload of each register
        load(2'd2, 16'hBEEF);
        load(2'd0, 16'h00F3);
        chk("R11 loads", {x_o, a_o}, {16'hBEEF, 4'h3});

        // R2 decode: 0x18A0 lies between the two memory ranges
        @(negedge clk);
        start = 1'b1; insn = 13'h18A0;
        @(negedge clk);
        start = 1'b0;
        chk("R2 gap is illegal", {illegal, mem_re}, 2'b10);
        repeat (2) @(negedge clk);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // B left by the final table vector
    function automatic logic [3:0] eb_last();
        return VEC[9][7:4];
    endfunction
endmodule